// File: doc/BRIEF.md
# Safety Operating Mode Controller

This block is the mode state machine of a safety logic controller. It sits between the user-programmed logic and the output drivers. For every output, on every clock, it decides one of three things: the user value passes through, the output is forced to the static low level, or the output is placed in its OFF-state. The choice depends on the current operating mode and on the fault flags.

Coming out of reset, the block runs a start-up self-test that is timed in milliseconds. It then waits without a configuration until an authorized, intact configuration is loaded. Only after that does it enter the run mode, the one mode in which user values reach the pins. Configuration and software upgrade each have their own mode, and in both every output is held low. A dangerous internal fault moves the block into a latched fatal mode on the next clock. A lost millisecond time base counts as such a fault. The fatal mode can be left only through reset.

An external fault is handled output by output. Each output has a selection that says whether the output is driven low or placed in its OFF-state when its external fault flag is raised. Every configuration attempt ends with exactly one strobe: accept or reject.

Top module: `safety_mode_ctrl`

## Requirements
- R1: During and directly after a synchronous reset, mode_o is 0 (start-up), every bit of out_o and off_en_o is 0, and neither configuration strobe is high.
- R2: The start-up mode lasts ST_MS millisecond ticks. It then moves to run mode (code 2) if a valid configuration is held, and to the unconfigured mode (code 1) if none is held. out_o equals user_out_i only in run mode.
- R3: A rising edge of cfg_req_i in the unconfigured or run mode enters configuration mode (code 3). In configuration mode out_o and off_en_o are all 0.
- R4: A configuration attempt ends when cfg_req_i falls. If cfg_pw_ok_i and cfg_crc_ok_i are both 1 on that clock, cfg_accept_o pulses for one cycle and the mode becomes start-up. Otherwise cfg_reject_o pulses for one cycle, the held configuration is invalidated and the mode becomes unconfigured. The two strobes are never high together.
- R5: An attempt still open after CFG_MAX_MS ticks is rejected and the mode becomes unconfigured. A new attempt needs cfg_req_i to go low and then high again.
- R6: While upg_req_i is high in the start-up, unconfigured or run mode, the block enters upgrade mode (code 4) with all outputs low. A simultaneous configuration request loses to the upgrade request. When upg_req_i drops, the mode becomes start-up, and the held configuration is kept.
- R7: int_fault_i high on a clock edge in any mode puts mode_o at 7 (fatal) with out_o and off_en_o all 0 after that same edge.
- R8: The fatal mode ignores configuration and upgrade requests and is left only by reset.
- R9: If no ms_tick_i pulse arrives for TICK_MAX_CLK consecutive clocks, the block enters the fatal mode.
- R10: In run mode, an output whose ext_fault_i bit is 1 drives out_o low. It sets its off_en_o bit if its dss_off_sel_i bit is 1 and clears it if that bit is 0. Outputs without an external fault pass the user value with off_en_o at 0.
- R11: In every mode other than run, out_o and off_en_o are all 0.
- R12: The mode codes on mode_o are 0 start-up, 1 unconfigured, 2 run, 3 configuration, 4 upgrade and 7 fatal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| cfg_req_i | input | 1 | Configuration attempt, held high for its duration |
| cfg_pw_ok_i | input | 1 | Password check passed |
| cfg_crc_ok_i | input | 1 | Configuration CRC check passed |
| upg_req_i | input | 1 | Software upgrade in progress |
| int_fault_i | input | 1 | Dangerous internal fault detected |
| ext_fault_i | input | N_OUT | Per-output external dangerous fault |
| dss_off_sel_i | input | N_OUT | Per-output choice: 1 OFF-state, 0 drive low |
| user_out_i | input | N_OUT | Output vector from the user logic |
| out_o | output | N_OUT | Gated output vector |
| off_en_o | output | N_OUT | Per-output OFF-state enable |
| mode_o | output | 3 | Current mode code |
| cfg_accept_o | output | 1 | One-cycle strobe: configuration accepted |
| cfg_reject_o | output | 1 | One-cycle strobe: configuration rejected |

## Verification
The assertions assume that reset is held for at least one clock before any property is sampled. They also assume that fault, request and tick inputs change only between clock edges, so each input is seen whole on a single edge. The bench drives every input on the falling edge and keeps the tick generator running through reset, except in the one test that stops it on purpose to provoke the time-base fault. Configuration requests are always dropped and raised again as clean level changes, so each attempt has exactly one end for the strobes to report.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [2:0] {
    M_START  = 3'd0,
    M_UNCONF = 3'd1,
    M_RUN    = 3'd2,
    M_CFG    = 3'd3,
    M_UPG    = 3'd4,
    M_FATAL  = 3'd7
  } mode_e;
endpackage

// File: rtl/smc_tick_sup.sv
// Watches the millisecond time base; flags a fault when it goes silent.
module smc_tick_sup #(
  parameter int TICK_MAX_CLK = 60000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic fault_o
);
  localparam int W = $clog2(TICK_MAX_CLK + 1);
  localparam logic [W-1:0] LIM = TICK_MAX_CLK[W-1:0];

  logic [W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (tick_i) begin
      gap_q <= '0;
    end else if (gap_q != LIM) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign fault_o = (gap_q == LIM);
endmodule

// File: rtl/smc_ms_timer.sv
// Counts millisecond ticks while run_i is high; clears when it is low.
module smc_ms_timer #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = LIMIT[W-1:0];

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/smc_fsm.sv
// Mode sequencing, configuration verdict and configuration validity.
module smc_fsm
  import smc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cfg_req_i,
  input  logic  cfg_pw_ok_i,
  input  logic  cfg_crc_ok_i,
  input  logic  upg_req_i,
  input  logic  int_fault_i,
  input  logic  tick_fault_i,
  input  logic  st_done_i,
  input  logic  cfg_to_i,
  output mode_e mode_d_o,
  output mode_e mode_q_o,
  output logic  accept_o,
  output logic  reject_o
);
  mode_e mode_q, mode_d;
  logic  cfg_req_q;
  logic  valid_q, valid_d;
  logic  acc_d, rej_d;
  logic  cfg_rise, cfg_fall, fatal;

  assign cfg_rise = cfg_req_i & ~cfg_req_q;
  assign cfg_fall = ~cfg_req_i & cfg_req_q;
  assign fatal    = int_fault_i | tick_fault_i;

  always_comb begin
    mode_d  = mode_q;
    valid_d = valid_q;
    acc_d   = 1'b0;
    rej_d   = 1'b0;
    if (mode_q != M_FATAL && fatal) begin
      mode_d = M_FATAL;
      if (mode_q == M_CFG) begin
        rej_d   = 1'b1;
        valid_d = 1'b0;
      end
    end else begin
      case (mode_q)
        M_START: begin
          if (upg_req_i)      mode_d = M_UPG;
          else if (st_done_i) mode_d = valid_q ? M_RUN : M_UNCONF;
        end
        M_UNCONF, M_RUN: begin
          if (upg_req_i)     mode_d = M_UPG;
          else if (cfg_rise) mode_d = M_CFG;
        end
        M_CFG: begin
          if (cfg_fall) begin
            if (cfg_pw_ok_i && cfg_crc_ok_i) begin
              acc_d   = 1'b1;
              valid_d = 1'b1;
              mode_d  = M_START;
            end else begin
              rej_d   = 1'b1;
              valid_d = 1'b0;
              mode_d  = M_UNCONF;
            end
          end else if (cfg_to_i) begin
            rej_d   = 1'b1;
            valid_d = 1'b0;
            mode_d  = M_UNCONF;
          end
        end
        M_UPG: begin
          if (!upg_req_i) mode_d = M_START;
        end
        default: mode_d = M_FATAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_START;
      cfg_req_q <= 1'b0;
      valid_q   <= 1'b0;
      accept_o  <= 1'b0;
      reject_o  <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      cfg_req_q <= cfg_req_i;
      valid_q   <= valid_d;
      accept_o  <= acc_d;
      reject_o  <= rej_d;
    end
  end

  assign mode_d_o = mode_d;
  assign mode_q_o = mode_q;
endmodule

// File: rtl/smc_out_gate.sv
// Per-output gating, registered from the next-cycle mode.
module smc_out_gate
  import smc_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode_d_i,
  input  logic [N_OUT-1:0] user_i,
  input  logic [N_OUT-1:0] ext_fault_i,
  input  logic [N_OUT-1:0] dss_off_i,
  output logic [N_OUT-1:0] out_o,
  output logic [N_OUT-1:0] off_o
);
  logic run;
  assign run = (mode_d_i == M_RUN);

  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        out_o[i] <= 1'b0;
        off_o[i] <= 1'b0;
      end else begin
        out_o[i] <= run & ~ext_fault_i[i] & user_i[i];
        off_o[i] <= run & ext_fault_i[i] & dss_off_i[i];
      end
    end
  end
endmodule

// File: rtl/safety_mode_ctrl.sv
module safety_mode_ctrl
  import smc_pkg::*;
#(
  parameter int N_OUT        = 8,
  parameter int ST_MS        = 10,
  parameter int CFG_MAX_MS   = 30000,
  parameter int TICK_MAX_CLK = 60000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick_i,
  input  logic             cfg_req_i,
  input  logic             cfg_pw_ok_i,
  input  logic             cfg_crc_ok_i,
  input  logic             upg_req_i,
  input  logic             int_fault_i,
  input  logic [N_OUT-1:0] ext_fault_i,
  input  logic [N_OUT-1:0] dss_off_sel_i,
  input  logic [N_OUT-1:0] user_out_i,
  output logic [N_OUT-1:0] out_o,
  output logic [N_OUT-1:0] off_en_o,
  output logic [2:0]       mode_o,
  output logic             cfg_accept_o,
  output logic             cfg_reject_o
);
  mode_e mode_d, mode_q;
  logic  tick_fault, st_done, cfg_to;

  smc_tick_sup #(.TICK_MAX_CLK(TICK_MAX_CLK)) tick_sup_i (
    .clk(clk), .rst(rst), .tick_i(ms_tick_i), .fault_o(tick_fault)
  );

  smc_ms_timer #(.LIMIT(ST_MS)) st_tmr_i (
    .clk(clk), .rst(rst), .run_i(mode_q == M_START),
    .tick_i(ms_tick_i), .done_o(st_done)
  );

  smc_ms_timer #(.LIMIT(CFG_MAX_MS)) cfg_tmr_i (
    .clk(clk), .rst(rst), .run_i(mode_q == M_CFG),
    .tick_i(ms_tick_i), .done_o(cfg_to)
  );

  smc_fsm fsm_i (
    .clk(clk), .rst(rst),
    .cfg_req_i(cfg_req_i), .cfg_pw_ok_i(cfg_pw_ok_i), .cfg_crc_ok_i(cfg_crc_ok_i),
    .upg_req_i(upg_req_i), .int_fault_i(int_fault_i), .tick_fault_i(tick_fault),
    .st_done_i(st_done), .cfg_to_i(cfg_to),
    .mode_d_o(mode_d), .mode_q_o(mode_q),
    .accept_o(cfg_accept_o), .reject_o(cfg_reject_o)
  );

  smc_out_gate #(.N_OUT(N_OUT)) gate_i (
    .clk(clk), .rst(rst), .mode_d_i(mode_d),
    .user_i(user_out_i), .ext_fault_i(ext_fault_i), .dss_off_i(dss_off_sel_i),
    .out_o(out_o), .off_o(off_en_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/smc_chk.sv
module smc_chk #(
  parameter int N_OUT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             int_fault_i,
  input logic [N_OUT-1:0] out_o,
  input logic [N_OUT-1:0] off_en_o,
  input logic [2:0]       mode_o,
  input logic             cfg_accept_o,
  input logic             cfg_reject_o
);
  // R7
  fault_to_fatal_chk: assert property (@(posedge clk) disable iff (rst)
    int_fault_i |=> (mode_o == 3'd7 && out_o == '0 && off_en_o == '0));
  // R8
  fatal_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd7) |=> (mode_o == 3'd7));
  // R11
  safe_outside_run_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 3'd2) |-> (out_o == '0 && off_en_o == '0));
  // R4
  one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_accept_o, cfg_reject_o}));
  // R4
  accept_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_accept_o |-> (mode_o == 3'd0));
  // R10
  off_never_high_chk: assert property (@(posedge clk) disable iff (rst)
    (off_en_o & out_o) == '0);
endmodule

bind safety_mode_ctrl smc_chk #(.N_OUT(N_OUT)) chk_i (
  .clk(clk), .rst(rst), .int_fault_i(int_fault_i),
  .out_o(out_o), .off_en_o(off_en_o), .mode_o(mode_o),
  .cfg_accept_o(cfg_accept_o), .cfg_reject_o(cfg_reject_o)
);

// File: tb/safety_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module safety_mode_ctrl_tb_top;
  localparam int N = 4;
  localparam int TICK_PER = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0, tick_en = 1'b1;
  logic cfg_req = 0, pw_ok = 0, crc_ok = 0, upg_req = 0, int_fault = 0;
  logic [N-1:0] ext_fault = '0, dss_sel = '0, user_out = '0;
  logic [N-1:0] out_w, off_w;
  logic [2:0]   mode_w;
  logic         acc_w, rej_w;

  int checks = 0, errors = 0, acc_cnt = 0, rej_cnt = 0;

  always #10 clk = ~clk;

  safety_mode_ctrl #(.N_OUT(N), .ST_MS(3), .CFG_MAX_MS(5), .TICK_MAX_CLK(40)) dut_i (
    .clk(clk), .rst(rst), .ms_tick_i(ms_tick), .cfg_req_i(cfg_req),
    .cfg_pw_ok_i(pw_ok), .cfg_crc_ok_i(crc_ok), .upg_req_i(upg_req),
    .int_fault_i(int_fault), .ext_fault_i(ext_fault), .dss_off_sel_i(dss_sel),
    .user_out_i(user_out), .out_o(out_w), .off_en_o(off_w), .mode_o(mode_w),
    .cfg_accept_o(acc_w), .cfg_reject_o(rej_w)
  );

  // tick generator and strobe counters, all on the falling edge
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div == TICK_PER - 1) ? 0 : div + 1;
      ms_tick = tick_en && (div == 0);
      if (acc_w) acc_cnt++;
      if (rej_w) rej_cnt++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic cfg_attempt(input logic pw, input logic crc);
    cfg_req = 1'b1;
    cyc(4);
    pw_ok = pw; crc_ok = crc;
    cfg_req = 1'b0;
    cyc(3);
    pw_ok = 0; crc_ok = 0;
  endtask

  // {user, ext_fault, dss_sel, exp_out, exp_off}
  localparam logic [19:0] VEC [6] = '{
    {4'hF, 4'h0, 4'h0, 4'hF, 4'h0},
    {4'hF, 4'hF, 4'h0, 4'h0, 4'h0},
    {4'hF, 4'hF, 4'hF, 4'h0, 4'hF},
    {4'hA, 4'h3, 4'h1, 4'h8, 4'h1},
    {4'h5, 4'hC, 4'h4, 4'h1, 4'h4},
    {4'h6, 4'h0, 4'hF, 4'h6, 4'h0}
  };

  initial begin
    int a0;
    // R1 reset state
    cyc(2);
    chk("R1 mode in reset", mode_w, 0);
    chk("R1 out in reset", out_w, 0);
    chk("R1 off in reset", off_w, 0);
    user_out = 4'hF;
    rst = 1'b0;
    cyc(1);
    chk("R1 mode after reset", mode_w, 0);
    chk("R1 no strobes", acc_cnt + rej_cnt, 0);
    cyc(60);
    // R2 no configuration -> unconfigured
    chk("R2 unconfigured after self-test", mode_w, 1);
    chk("R11 out low unconfigured", out_w, 0);

    // R3 / R4 bad password
    cfg_req = 1'b1; cyc(3);
    chk("R3 config mode", mode_w, 3);
    chk("R3 out low in config", out_w, 0);
    cfg_req = 1'b0; pw_ok = 0; crc_ok = 1; cyc(3); crc_ok = 0;
    chk("R4 reject on bad password", rej_cnt, 1);
    chk("R4 unconfigured after reject", mode_w, 1);
    cfg_attempt(1'b1, 1'b0);
    chk("R4 reject on bad crc", rej_cnt, 2);
    chk("R4 no accept so far", acc_cnt, 0);
    cfg_attempt(1'b1, 1'b1);
    chk("R4 accept strobe", acc_cnt, 1);
    chk("R12 start-up code after accept", mode_w, 0);
    cyc(60);
    chk("R2 run after valid config", mode_w, 2);

    // R10 table walk in run mode
    foreach (VEC[k]) begin
      user_out  = VEC[k][19:16];
      ext_fault = VEC[k][15:12];
      dss_sel   = VEC[k][11:8];
      cyc(2);
      chk($sformatf("R10 out vec %0d", k), out_w, VEC[k][7:4]);
      chk($sformatf("R10 off vec %0d", k), off_w, VEC[k][3:0]);
    end
    ext_fault = '0; user_out = 4'hF;

    // R5 timeout
    a0 = rej_cnt;
    cfg_req = 1'b1; cyc(3);
    chk("R3 config from run", mode_w, 3);
    cyc(75);
    chk("R5 timeout reject", rej_cnt, a0 + 1);
    chk("R5 unconfigured after timeout", mode_w, 1);
    cyc(30);
    chk("R5 no re-entry while held", mode_w, 1);
    cfg_req = 1'b0; cyc(2);
    cfg_attempt(1'b1, 1'b1);
    cyc(60);
    chk("R2 run again", mode_w, 2);

    // R6 upgrade beats config request
    upg_req = 1'b1; cfg_req = 1'b1; cyc(2);
    chk("R6 upgrade mode", mode_w, 4);
    chk("R6 out low in upgrade", out_w, 0);
    upg_req = 1'b0; cfg_req = 1'b0; cyc(2);
    chk("R6 start-up after upgrade", mode_w, 0);
    cyc(60);
    chk("R6 config kept across upgrade", mode_w, 2);
    chk("R2 user passes in run", out_w, 15);

    // R7 / R8 internal fault
    int_fault = 1'b1; cyc(1); int_fault = 1'b0;
    chk("R7 fatal next cycle", mode_w, 7);
    chk("R7 out low", out_w, 0);
    cfg_req = 1'b1; upg_req = 1'b1; cyc(3);
    cfg_req = 1'b0; upg_req = 1'b0; pw_ok = 1; crc_ok = 1; cyc(80);
    pw_ok = 0; crc_ok = 0;
    chk("R8 fatal latched", mode_w, 7);
    do_reset(); cyc(1);
    chk("R8 reset leaves fatal", mode_w, 0);

    // R9 tick loss
    cyc(5);
    tick_en = 1'b0; cyc(50);
    chk("R9 fatal on tick loss", mode_w, 7);
    tick_en = 1'b1;
    do_reset(); cyc(60);
    chk("R9 recovery to unconfigured", mode_w, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule